// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Status

This block buffers audio samples between a software-facing side and a serial audio engine. It holds two rings of eight 32-bit words. The transmit ring is filled by software and emptied by the serializer. The receive ring is filled by the serializer and emptied by software. Each ring reports its occupancy, full, empty and a programmable threshold status. Together the two rings raise sticky error flags, DMA requests and interrupt lines.

Data moves through four valid/ready streams.

- **Transmit write (software side).** `tx_s_ready` is high while the transmit ring is not full. A write offered while `tx_s_ready` is low is not held back. It is discarded and recorded as an overflow.
- **Transmit drain (serializer side).** `tx_m_valid` means a word is waiting. A transfer happens on a cycle where both `tx_m_valid` and `tx_m_ready` are high.
- **Receive fill (serializer side).** `rx_s_ready` is always high. A push into a full receive ring replaces the oldest word.
- **Receive read (software side).** A read taken while `rx_m_valid` is low returns zero and is recorded as an underflow.

Each ring has a one-cycle clear pulse. The clear moves that ring's pointers back to slot 0 and sets its count to zero. The stored words are not changed.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both counts are 0, both empty outputs are 1, both full outputs are 0, and all error flags are 0. A count never exceeds 8. Full is 1 exactly at count 8 and empty is 1 exactly at count 0.
- R2: Each ring delivers its words in the order they were accepted.
- R3: While the transmit ring is full, `tx_s_ready` is 0. A write offered in that state is discarded, the count stays at 8, and `err_flags[0]` (transmit overflow) becomes 1.
- R4: A receive push while the ring is full and no read is taken overwrites the oldest word. The count stays at 8 and `err_flags[1]` (receive overflow) becomes 1. The next word read is the second-oldest word that was pushed.
- R5: A receive read while the ring is empty presents 0 on `rx_m_data`. It leaves the count at 0 and sets `err_flags[2]` (receive underflow).
- R6: `tx_thr` is 1 exactly when `tx_cnt` is less than or equal to the 3-bit `tx_level`.
- R7: `rx_thr` is 1 exactly when `rx_cnt` is greater than or equal to `rx_level`+1. Codes 0 to 7 therefore mean 1 to 8 words.
- R8: A clear pulse makes that ring's count 0 on the next cycle. A push or pop in the same cycle is ignored. Stored words survive the clear: `tx_m_data` always shows the slot at the read pointer, so after a transmit clear it shows the word last written to slot 0.
- R9: The error flags are sticky. Writing 1 to a bit of `err_w1c` clears that flag. If a new error event and a clear arrive in the same cycle, the event wins.
- R10: `tx_dma_req` = `tx_dma_en` and not full. `rx_dma_req` = `rx_dma_en` and not empty.
- R11: `irq_en` bit 0 enables transmit threshold, bit 1 transmit overflow, bit 2 receive threshold, bit 3 receive overflow, and bit 4 receive underflow. `tx_irq` is the OR of the enabled transmit sources. `rx_irq` is the OR of the enabled receive sources. `irq` = `tx_irq` OR `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clr | input | 1 | Clear pulse for the transmit ring |
| rx_clr | input | 1 | Clear pulse for the receive ring |
| tx_s_valid | input | 1 | Software offers a transmit word |
| tx_s_ready | output | 1 | Transmit ring has room |
| tx_s_data | input | 32 | Transmit word from software |
| tx_m_valid | output | 1 | Transmit word available to the serializer |
| tx_m_ready | input | 1 | Serializer takes the word |
| tx_m_data | output | 32 | Word at the transmit read pointer |
| rx_s_valid | input | 1 | Serializer pushes a received word |
| rx_s_ready | output | 1 | Always 1 (the ring overwrites when full) |
| rx_s_data | input | 32 | Received word |
| rx_m_valid | output | 1 | Receive ring holds a word |
| rx_m_ready | input | 1 | Software reads a word |
| rx_m_data | output | 32 | Oldest received word, or 0 when empty |
| tx_level | input | 3 | Transmit threshold code |
| rx_level | input | 3 | Receive threshold code |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_cnt | output | 4 | Transmit occupancy, 0 to 8 |
| rx_cnt | output | 4 | Receive occupancy, 0 to 8 |
| tx_full | output | 1 | Transmit ring full |
| tx_empty | output | 1 | Transmit ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_empty | output | 1 | Receive ring empty |
| tx_thr | output | 1 | Transmit threshold status |
| rx_thr | output | 1 | Receive threshold status |
| err_flags | output | 3 | Sticky flags: bit 0 transmit overflow, bit 1 receive overflow, bit 2 receive underflow |
| err_w1c | input | 3 | Write-1-to-clear strobes for `err_flags` |
| irq_en | input | 5 | Per-source interrupt enables |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that clear, push, pop and `err_w1c` are single-cycle strobes sampled on the rising edge. They also assume that a pop on an empty transmit ring has no meaning, because the serializer only pops while `tx_m_valid` is high. The stimulus holds each strobe for exactly one cycle between falling edges. It raises `tx_m_ready` only after it has seen `tx_m_valid`. It deliberately drives pushes into full rings and reads of the empty receive ring, so that the overflow, overwrite and underflow paths are exercised inside these assumptions.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int unsigned AFP_WIDTH = 32;
  localparam int unsigned AFP_DEPTH = 8;
  localparam int unsigned AFP_AW    = $clog2(AFP_DEPTH);
  localparam int unsigned AFP_CW    = $clog2(AFP_DEPTH + 1);

  // sticky error flag positions
  localparam int unsigned ERR_TX_OVF = 0;
  localparam int unsigned ERR_RX_OVF = 1;
  localparam int unsigned ERR_RX_UDF = 2;
  localparam int unsigned ERR_N      = 3;

  // interrupt enable positions
  localparam int unsigned IEN_TX_THR = 0;
  localparam int unsigned IEN_TX_OVF = 1;
  localparam int unsigned IEN_RX_THR = 2;
  localparam int unsigned IEN_RX_OVF = 3;
  localparam int unsigned IEN_RX_UDF = 4;
  localparam int unsigned IEN_N      = 5;
endpackage

// File: rtl/afp_ring.sv
module afp_ring #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned DEPTH     = 8,
  parameter bit          OVERWRITE = 1'b0,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    cnt,
  output logic             full,
  output logic             empty,
  output logic             push_full_evt,
  output logic             pop_empty_evt
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_push, do_pop, rd_adv;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign head   = mem[rptr];
  assign do_pop = pop && !empty && !clr;
  assign pop_empty_evt = pop && empty && !clr;

  generate
    if (OVERWRITE) begin : g_over
      // a push into a full ring evicts the oldest word
      assign do_push       = push && !clr;
      assign rd_adv        = do_pop || (do_push && full);
      assign push_full_evt = push && full && !pop && !clr;
    end else begin : g_drop
      assign do_push       = push && !clr && !full;
      assign rd_adv        = do_pop;
      assign push_full_evt = push && full && !clr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (rd_adv)  rptr <= nxt(rptr);
      cnt <= cnt + CW'(do_push) - CW'(rd_adv);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  assert_empty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/afp_flags.sv
module afp_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~w1c) | set;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c & ~set)) |=> ((flags & $past(w1c & ~set)) == '0));
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import afp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_clr,
  input  logic                 rx_clr,
  input  logic                 tx_s_valid,
  output logic                 tx_s_ready,
  input  logic [AFP_WIDTH-1:0] tx_s_data,
  output logic                 tx_m_valid,
  input  logic                 tx_m_ready,
  output logic [AFP_WIDTH-1:0] tx_m_data,
  input  logic                 rx_s_valid,
  output logic                 rx_s_ready,
  input  logic [AFP_WIDTH-1:0] rx_s_data,
  output logic                 rx_m_valid,
  input  logic                 rx_m_ready,
  output logic [AFP_WIDTH-1:0] rx_m_data,
  input  logic [AFP_AW-1:0]    tx_level,
  input  logic [AFP_AW-1:0]    rx_level,
  input  logic                 tx_dma_en,
  input  logic                 rx_dma_en,
  output logic                 tx_dma_req,
  output logic                 rx_dma_req,
  output logic [AFP_CW-1:0]    tx_cnt,
  output logic [AFP_CW-1:0]    rx_cnt,
  output logic                 tx_full,
  output logic                 tx_empty,
  output logic                 rx_full,
  output logic                 rx_empty,
  output logic                 tx_thr,
  output logic                 rx_thr,
  output logic [ERR_N-1:0]     err_flags,
  input  logic [ERR_N-1:0]     err_w1c,
  input  logic [IEN_N-1:0]     irq_en,
  output logic                 tx_irq,
  output logic                 rx_irq,
  output logic                 irq
);
  logic [AFP_WIDTH-1:0] rx_head;
  logic tx_drop, tx_pop_empty_unused, rx_over, rx_under;
  logic [ERR_N-1:0] err_set;

  afp_ring #(.WIDTH(AFP_WIDTH), .DEPTH(AFP_DEPTH), .OVERWRITE(1'b0)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_s_valid), .push_data(tx_s_data), .pop(tx_m_ready),
    .head(tx_m_data), .cnt(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_full_evt(tx_drop), .pop_empty_evt(tx_pop_empty_unused)
  );

  afp_ring #(.WIDTH(AFP_WIDTH), .DEPTH(AFP_DEPTH), .OVERWRITE(1'b1)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_s_valid), .push_data(rx_s_data), .pop(rx_m_ready),
    .head(rx_head), .cnt(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_full_evt(rx_over), .pop_empty_evt(rx_under)
  );

  assign tx_s_ready = !tx_full;
  assign tx_m_valid = !tx_empty;
  assign rx_s_ready = 1'b1;
  assign rx_m_valid = !rx_empty;
  assign rx_m_data  = rx_empty ? '0 : rx_head;

  // transmit: at or below level; receive: at or above level plus one
  assign tx_thr = (tx_cnt <= AFP_CW'(tx_level));
  assign rx_thr = (rx_cnt >= (AFP_CW'(rx_level) + AFP_CW'(1)));

  assign tx_dma_req = tx_dma_en && !tx_full;
  assign rx_dma_req = rx_dma_en && !rx_empty;

  always_comb begin
    err_set             = '0;
    err_set[ERR_TX_OVF] = tx_drop;
    err_set[ERR_RX_OVF] = rx_over;
    err_set[ERR_RX_UDF] = rx_under;
  end

  afp_flags #(.N(ERR_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(err_set), .w1c(err_w1c), .flags(err_flags)
  );

  assign tx_irq = (irq_en[IEN_TX_THR] && tx_thr) ||
                  (irq_en[IEN_TX_OVF] && err_flags[ERR_TX_OVF]);
  assign rx_irq = (irq_en[IEN_RX_THR] && rx_thr) ||
                  (irq_en[IEN_RX_OVF] && err_flags[ERR_RX_OVF]) ||
                  (irq_en[IEN_RX_UDF] && err_flags[ERR_RX_UDF]);
  assign irq = tx_irq || rx_irq;

  assert_tx_drop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_s_valid && !tx_clr) |=> (err_flags[ERR_TX_OVF] && tx_full));
  assert_rx_over_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_s_valid && !rx_m_ready && !rx_clr) |=> err_flags[ERR_RX_OVF]);
  assert_rx_under_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_m_ready && !rx_clr) |=> err_flags[ERR_RX_UDF]);
  assert_rx_thr_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_thr |-> !rx_empty);
endmodule

// File: tb/test_audio_fifo_pair.sv
module test_audio_fifo_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_clr = 0, rx_clr = 0;
  logic tx_s_valid = 0, tx_m_ready = 0, rx_s_valid = 0, rx_m_ready = 0;
  logic [31:0] tx_s_data = '0, rx_s_data = '0;
  logic tx_s_ready, tx_m_valid, rx_s_ready, rx_m_valid;
  logic [31:0] tx_m_data, rx_m_data;
  logic [2:0] tx_level = 3'd0, rx_level = 3'd7;
  logic tx_dma_en = 1, rx_dma_en = 1, tx_dma_req, rx_dma_req;
  logic [3:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_thr, rx_thr;
  logic [2:0] err_flags, err_w1c = '0;
  logic [4:0] irq_en = '0;
  logic tx_irq, rx_irq, irq;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [31:0] txq[$], rxq[$];

  always #2 clk = ~clk;

  audio_fifo_pair i_audio_fifo_pair (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers one transmit word; accepted words go to the scoreboard
  task automatic tx_push(input logic [31:0] d, input bit accept);
    @(negedge clk) tx_s_valid = 1; tx_s_data = d;
    if (accept) txq.push_back(d);
    @(negedge clk) tx_s_valid = 0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk) rx_s_valid = 1; rx_s_data = d;
    if (rxq.size() == 8) void'(rxq.pop_front());
    rxq.push_back(d);
    @(negedge clk) rx_s_valid = 0;
  endtask

  // monitors: compare produced word against the scoreboard head
  task automatic tx_take();
    @(negedge clk);
    chk("R2 tx valid", tx_m_valid, 1'b1);
    chk("R2 tx order", tx_m_data, txq.pop_front());
    tx_m_ready = 1;
    @(negedge clk) tx_m_ready = 0;
  endtask

  task automatic rx_take();
    @(negedge clk);
    chk("R2 rx order", rx_m_data, rxq.pop_front());
    rx_m_ready = 1;
    @(negedge clk) rx_m_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_cnt", tx_cnt, 0);
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 empties", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk("R1 err", err_flags, 0);
    chk("R10 dma idle", {tx_dma_req, rx_dma_req}, 2'b10);

    for (int i = 0; i < 8; i++) tx_push(32'hA000_0000 + i, 1);
    chk("R1 tx full cnt", tx_cnt, 8);
    chk("R1 tx full", tx_full, 1);
    chk("R3 ready low", tx_s_ready, 0);
    chk("R10 tx dma full", tx_dma_req, 0);
    tx_push(32'hDEAD_BEEF, 0);
    chk("R3 cnt held", tx_cnt, 8);
    chk("R3 ovf flag", err_flags[0], 1);

    tx_level = 3'd3;
    for (int i = 0; i < 4; i++) tx_take();
    @(negedge clk);
    chk("R6 cnt4 above", tx_thr, 0);
    tx_take();
    @(negedge clk);
    chk("R6 cnt3 at level", tx_thr, 1);
    for (int i = 0; i < 3; i++) tx_take();
    @(negedge clk);
    chk("R2 tx drained", tx_empty, 1);

    irq_en = 5'b00010;
    @(negedge clk);
    chk("R11 tx ovf irq", {tx_irq, rx_irq, irq}, 3'b101);
    err_w1c = 3'b001;
    @(negedge clk) err_w1c = 0;
    chk("R9 w1c tx ovf", err_flags[0], 0);
    chk("R11 irq off", irq, 0);

    for (int i = 0; i < 7; i++) rx_push(32'hB000_0000 + i);
    chk("R7 cnt7 level7", rx_thr, 0);
    rx_push(32'hB000_0007);
    chk("R7 cnt8 level7", rx_thr, 1);
    chk("R1 rx full", rx_full, 1);
    chk("R10 rx dma", rx_dma_req, 1);
    rx_push(32'hB000_0008);
    rx_push(32'hB000_0009);
    chk("R4 cnt held", rx_cnt, 8);
    chk("R4 ovf flag", err_flags[1], 1);

    rx_level = 3'd2;
    for (int i = 0; i < 5; i++) rx_take();
    chk("R7 cnt3 level2", rx_thr, 1);
    rx_take();
    chk("R7 cnt2 level2", rx_thr, 0);
    rx_take();
    rx_take();
    chk("R10 rx dma empty", rx_dma_req, 0);

    @(negedge clk);
    chk("R5 zero data", rx_m_data, 0);
    rx_m_ready = 1;
    @(negedge clk) rx_m_ready = 0;
    chk("R5 udf flag", err_flags[2], 1);
    chk("R5 cnt", rx_cnt, 0);
    rx_m_ready = 1; err_w1c = 3'b100;
    @(negedge clk) rx_m_ready = 0; err_w1c = 0;
    chk("R9 set beats clear", err_flags[2], 1);
    err_w1c = 3'b100;
    @(negedge clk) err_w1c = 0;
    chk("R9 w1c udf", err_flags[2], 0);

    irq_en = 5'b01000;
    @(negedge clk);
    chk("R11 rx ovf irq", {tx_irq, rx_irq, irq}, 3'b011);
    irq_en = 5'b00001;
    @(negedge clk);
    chk("R11 tx thr irq", {tx_irq, rx_irq, irq}, 3'b101);
    irq_en = 0;

    tx_push(32'hC000_0000, 1);
    tx_push(32'hC000_0001, 1);
    chk("R8 pre clear", tx_cnt, 2);
    @(negedge clk) tx_clr = 1; tx_s_valid = 1; tx_s_data = 32'hEEEE_0000;
    @(negedge clk) tx_clr = 0; tx_s_valid = 0;
    txq.delete();
    chk("R8 clear cnt", tx_cnt, 0);
    chk("R8 storage kept", tx_m_data, 32'hC000_0000);
    tx_push(32'hC000_0002, 1);
    tx_take();
    @(negedge clk) tx_clr = 1;
    @(negedge clk) tx_clr = 0;
    chk("R8 slot0 retained", tx_m_data, 32'hC000_0002);

    for (int i = 0; i < 3; i++) rx_push(32'hD000_0000 + i);
    @(negedge clk) rx_clr = 1;
    @(negedge clk) rx_clr = 0;
    rxq.delete();
    chk("R8 rx clear", {rx_cnt, rx_empty}, {4'd0, 1'b1});
    chk("R8 rx data masked", rx_m_data, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule